// File: doc/BRIEF.md
# Segmented Packet Bus Framing Checker

This block watches a transmit local bus that carries packet data on several parallel 128-bit segments each clock. Every segment has its own qualifiers: an enable, a start marker, an end marker, a channel number and an error marker. The checker changes nothing on the bus and stores no data. It checks only the framing of the packets that pass.

On every clock the checker walks the enabled segments from index 0 upward. It keeps one open-packet bit for each channel. A segment sees the channel state left by the lower-indexed segments of the same cycle, so several starts and ends can land in one cycle, and both can land on one segment. Four kinds of rule break are caught: a start on a channel that is already open, traffic on a channel with no open packet, mixing of channels while burst interleaving is switched off, and an error marker on a segment that is not an end. Each kind latches a sticky flag. One combined output reports that any flag is set.

Top module: `seg_bus_checker`

## Requirements
- R1: A synchronous active-low reset clears all violation flags to 0 and marks every channel as having no open packet.
- R2: A segment whose enable bit is 0 has no effect: its start, end, channel and error bits neither change channel state nor set any flag.
- R3: An enabled segment with start and end both high carries a whole packet: it sets no flag on a closed channel, and its channel is closed again afterwards.
- R4: An enabled start on a channel whose packet is still open sets flag bit 0 (duplicate start).
- R5: An enabled segment without start (data or end) on a channel with no open packet sets flag bit 1 (data outside packet).
- R6: When `ilv_mode` is 0, an enabled segment arriving while some channel other than its own has an open packet sets flag bit 2 (interleave). When `ilv_mode` is 1, interleaved channels set no flag.
- R7: An enabled segment with the error bit high and the end bit low sets flag bit 3 (misplaced error). An error bit on an enabled end segment is legal.
- R8: Within one cycle the segments are evaluated in ascending index order, and each segment sees the channel updates made by the lower-indexed segments.
- R9: The flags are registered, so a rule break shows on `viol_flags` one clock after it is sampled. Each flag stays set until reset. `viol_any` is the OR of the four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ilv_mode | input | 1 | 1 = channels may interleave between segments |
| seg_en | input | NUM_SEGS | Per-segment enable |
| seg_sop | input | NUM_SEGS | Per-segment start of packet |
| seg_eop | input | NUM_SEGS | Per-segment end of packet |
| seg_err | input | NUM_SEGS | Per-segment packet error marker |
| seg_chan | input | NUM_SEGS*CH_W | Channel of each segment; segment i in bits [i*CH_W +: CH_W] |
| viol_flags | output | 4 | Sticky flags: bit0 duplicate start, bit1 outside packet, bit2 interleave, bit3 misplaced error |
| viol_any | output | 1 | OR of the sticky flags |

## Verification
Every result of this block is due exactly one clock after the stimulus cycle, because the flags are the only registered outputs and the channel state reaches them through combinational segment stages. The bench drives each stimulus cycle on a falling edge and lets one rising edge register it. It compares the flags on the next falling edge, then clears the enables. It resets before each scenario, so each expected flag word follows only from the segments of that scenario. Cross-cycle effects such as closing or reopening a channel are checked by a probe segment in the next cycle, whose flag is again compared one edge later.

// File: rtl/seg_chk_pkg.sv
// Shared types for the segmented bus framing checker.
// Assumes: the flag word order is fixed and visible at the top ports.
package seg_chk_pkg;

    // One bit per framing rule; the bit position is the port encoding.
    typedef struct packed {
        logic err_misuse;   // bit 3: error marker without end
        logic interleave;   // bit 2: channel mix with interleaving off
        logic orphan;       // bit 1: traffic on a closed channel
        logic dup_sop;      // bit 0: start on an open channel
    } viol_t;

    localparam int VIOL_W = $bits(viol_t);

endpackage

// File: rtl/seg_stage.sv
// One segment evaluation stage. It takes the channel state left by the
// lower-indexed segments, applies this segment's start/end markers and
// reports which framing rules this segment breaks.
// Assumes: NUM_CHANS is a power of two so every channel code is in range.
// clk/rst_n serve only the embedded assertions.
module seg_stage
    import seg_chk_pkg::*;
#(
    parameter int NUM_CHANS = 256,
    localparam int CH_W  = $clog2(NUM_CHANS),
    localparam int CNT_W = $clog2(NUM_CHANS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ilv_mode,
    input  logic                 en,
    input  logic                 sop,
    input  logic                 eop,
    input  logic                 err,
    input  logic [CH_W-1:0]      ch,
    input  logic [NUM_CHANS-1:0] vec_in,
    input  logic [CNT_W-1:0]     cnt_in,
    output logic [NUM_CHANS-1:0] vec_out,
    output logic [CNT_W-1:0]     cnt_out,
    output viol_t                viol
);

    logic was_open;
    logic now_open;
    logic other_open;

    // Evaluate the rules for this segment and forward the updated channel state.
    always_comb begin
        vec_out    = vec_in;
        cnt_out    = cnt_in;
        viol       = '0;
        was_open   = vec_in[ch];
        other_open = (cnt_in - CNT_W'(was_open)) != '0;
        now_open   = was_open;
        if (en) begin
            viol.err_misuse = err && !eop;
            viol.interleave = !ilv_mode && other_open;
            if (sop) begin
                viol.dup_sop = was_open;
                now_open     = !eop;
            end else begin
                viol.orphan  = !was_open;
                now_open     = was_open && !eop;
            end
            vec_out[ch] = now_open;
            if (now_open && !was_open) begin
                cnt_out = cnt_in + CNT_W'(1);
            end else if (!now_open && was_open) begin
                cnt_out = cnt_in - CNT_W'(1);
            end
        end
    end

    // R2: a disabled segment forwards the channel state untouched
    a_r2_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (vec_out == vec_in && cnt_out == cnt_in));

    // R3: a single-segment packet leaves its channel closed
    a_r3_short_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sop && eop) |-> !vec_out[ch]);

    // R4: a start without end leaves its channel open
    a_r4_sop_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sop && !eop) |-> vec_out[ch]);

endmodule

// File: rtl/viol_accum.sv
// Sticky accumulator for the per-segment rule reports.
// Assumes: reports are valid every cycle; disabled segments report zero.
module viol_accum
    import seg_chk_pkg::*;
#(
    parameter int NUM_SEGS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  viol_t [NUM_SEGS-1:0] seg_viol,
    output viol_t                flags_q
);

    viol_t cycle_viol;

    // Merge the reports of all segments in this cycle.
    always_comb begin
        cycle_viol = '0;
        for (int s = 0; s < NUM_SEGS; s++) begin
            cycle_viol = cycle_viol | seg_viol[s];
        end
    end

    // Latch every report until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_q | cycle_viol;
        end
    end

    // R9: a set flag never clears while out of reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q != '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/seg_bus_checker.sv
// Framing checker for a transmit bus split into NUM_SEGS parallel segments.
// It holds one open-packet bit per channel plus a count of open channels.
// The segment stages are chained in index order, so segment i sees the
// updates of segments 0..i-1 in the same cycle. It never alters the bus.
// Assumes: NUM_CHANS is a power of two; reset is synchronous, active low.
module seg_bus_checker
    import seg_chk_pkg::*;
#(
    parameter int NUM_SEGS  = 4,
    parameter int NUM_CHANS = 256,
    localparam int CH_W  = $clog2(NUM_CHANS),
    localparam int CNT_W = $clog2(NUM_CHANS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ilv_mode,
    input  logic [NUM_SEGS-1:0]      seg_en,
    input  logic [NUM_SEGS-1:0]      seg_sop,
    input  logic [NUM_SEGS-1:0]      seg_eop,
    input  logic [NUM_SEGS-1:0]      seg_err,
    input  logic [NUM_SEGS*CH_W-1:0] seg_chan,
    output logic [VIOL_W-1:0]        viol_flags,
    output logic                     viol_any
);

    logic [NUM_CHANS-1:0] open_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [NUM_CHANS-1:0] vec_chain [NUM_SEGS+1];
    logic [CNT_W-1:0]     cnt_chain [NUM_SEGS+1];
    viol_t [NUM_SEGS-1:0] seg_viol;
    viol_t                flags_q;

    assign vec_chain[0] = open_q;
    assign cnt_chain[0] = cnt_q;

    // One stage per segment, chained in ascending index order (R8).
    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
        seg_stage #(.NUM_CHANS(NUM_CHANS)) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .ilv_mode (ilv_mode),
            .en       (seg_en[s]),
            .sop      (seg_sop[s]),
            .eop      (seg_eop[s]),
            .err      (seg_err[s]),
            .ch       (seg_chan[s*CH_W +: CH_W]),
            .vec_in   (vec_chain[s]),
            .cnt_in   (cnt_chain[s]),
            .vec_out  (vec_chain[s+1]),
            .cnt_out  (cnt_chain[s+1]),
            .viol     (seg_viol[s])
        );
    end

    // Register the channel state left by the last segment (R1 clears it).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
            cnt_q  <= '0;
        end else begin
            open_q <= vec_chain[NUM_SEGS];
            cnt_q  <= cnt_chain[NUM_SEGS];
        end
    end

    viol_accum #(.NUM_SEGS(NUM_SEGS)) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg_viol (seg_viol),
        .flags_q  (flags_q)
    );

    // Drive the flag ports from the sticky register.
    always_comb begin
        viol_flags = flags_q;
        viol_any   = |flags_q;
    end

    // R6: the open-channel count used by the interleave rule tracks the bit vector
    a_r6_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q == CNT_W'($countones(open_q)));

    // R1: the cycle after reset leaves no channel open and no flag set
    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (open_q == '0 && flags_q == '0));

endmodule

// File: tb/test_seg_bus_checker.sv
`timescale 1ns/1ps
module test_seg_bus_checker;

    localparam int NS   = 4;
    localparam int NC   = 256;
    localparam int CW   = $clog2(NC);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ilv_mode = 1'b0;
    logic [NS-1:0]  seg_en = '0, seg_sop = '0, seg_eop = '0, seg_err = '0;
    logic [NS*CW-1:0] seg_chan = '0;
    logic [3:0]     viol_flags;
    logic           viol_any;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    seg_bus_checker #(.NUM_SEGS(NS), .NUM_CHANS(NC)) i_seg_bus_checker (
        .clk(clk), .rst_n(rst_n), .ilv_mode(ilv_mode),
        .seg_en(seg_en), .seg_sop(seg_sop), .seg_eop(seg_eop),
        .seg_err(seg_err), .seg_chan(seg_chan),
        .viol_flags(viol_flags), .viol_any(viol_any)
    );

    // Load one segment's qualifiers for the coming cycle.
    task automatic seg_set(input int idx, input logic en, input logic sop,
                           input logic eop, input logic err, input int ch);
        seg_en[idx]  = en;
        seg_sop[idx] = sop;
        seg_eop[idx] = eop;
        seg_err[idx] = err;
        seg_chan[idx*CW +: CW] = CW'(ch);
    endtask

    // Let one rising edge sample the loaded segments, then clear them.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        seg_en = '0; seg_sop = '0; seg_eop = '0; seg_err = '0; seg_chan = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic check(input logic [3:0] exp, input string tag);
        n_checks++;
        if (viol_flags !== exp || viol_any !== (|exp)) begin
            n_fail++;
            $display("FAIL %s: flags=%b any=%b expected flags=%b any=%b",
                     tag, viol_flags, viol_any, exp, |exp);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(4'b0000, "R1 flags clear after reset");
        seg_set(0, 1, 1, 0, 0, 17); step();
        check(4'b0000, "R1 no channel open after reset");
    endtask

    task automatic t_disabled();
        do_reset();
        seg_set(0, 0, 1, 0, 1, 5); seg_set(1, 0, 0, 1, 1, 6); step();
        check(4'b0000, "R2 disabled segments set no flag");
        seg_set(0, 1, 0, 1, 0, 5); step();
        check(4'b0010, "R2 disabled start opened nothing");
    endtask

    task automatic t_short();
        do_reset();
        seg_set(0, 1, 1, 1, 0, 7); step();
        check(4'b0000, "R3 single-segment packet legal");
        seg_set(2, 1, 1, 1, 0, 7); step();
        check(4'b0000, "R3 channel closed after short packet");
    endtask

    task automatic t_dup();
        do_reset();
        seg_set(0, 1, 1, 0, 0, 9); step();
        check(4'b0000, "R4 first start legal");
        seg_set(1, 1, 1, 0, 0, 9); step();
        check(4'b0001, "R4 second start on open channel");
    endtask

    task automatic t_orphan();
        do_reset();
        seg_set(3, 1, 0, 0, 0, 255); step();
        check(4'b0010, "R5 data on closed channel");
        do_reset();
        seg_set(0, 1, 0, 1, 0, 0); step();
        check(4'b0010, "R5 end on closed channel");
    endtask

    task automatic t_interleave();
        do_reset();
        ilv_mode = 1'b0;
        seg_set(0, 1, 1, 0, 0, 1); seg_set(1, 1, 1, 0, 0, 2); step();
        check(4'b0100, "R6 channel mix with interleaving off");
        do_reset();
        ilv_mode = 1'b1;
        seg_set(0, 1, 1, 0, 0, 1); seg_set(1, 1, 1, 0, 0, 2);
        seg_set(2, 1, 0, 1, 0, 1); seg_set(3, 1, 0, 1, 0, 2); step();
        check(4'b0000, "R6 channel mix legal with interleaving on");
        seg_set(0, 1, 0, 1, 0, 1); step();
        check(4'b0010, "R6 interleaved packets both closed");
        ilv_mode = 1'b0;
        do_reset();
        seg_set(0, 1, 1, 0, 0, 4); step();
        seg_set(0, 1, 0, 0, 0, 4); seg_set(1, 1, 0, 1, 0, 4); step();
        check(4'b0000, "R6 same channel continues with interleaving off");
    endtask

    task automatic t_err();
        do_reset();
        seg_set(1, 1, 1, 0, 1, 4); step();
        check(4'b1000, "R7 error marker without end");
        do_reset();
        seg_set(0, 1, 1, 1, 1, 4); step();
        check(4'b0000, "R7 error marker on end legal");
    endtask

    task automatic t_order();
        do_reset();
        seg_set(0, 1, 1, 0, 0, 3); seg_set(1, 1, 0, 1, 0, 3); step();
        check(4'b0000, "R8 start then end in one cycle");
        do_reset();
        seg_set(0, 1, 0, 1, 0, 3); seg_set(1, 1, 1, 0, 0, 3); step();
        check(4'b0010, "R8 end before start in one cycle");
        seg_set(0, 1, 1, 0, 0, 3); step();
        check(4'b0011, "R8 later start left channel open");
    endtask

    task automatic t_sticky();
        do_reset();
        seg_set(0, 1, 0, 0, 0, 12); step();
        check(4'b0010, "R9 flag one cycle after violation");
        repeat (5) step();
        check(4'b0010, "R9 flag held over idle cycles");
        do_reset();
        check(4'b0000, "R9 reset clears sticky flag");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_short();
        t_dup();
        t_orphan();
        t_interleave();
        t_err();
        t_order();
        t_sticky();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule